// File: doc/BRIEF.md
# Floating-Point Load/Store Address Sequencer

This block carries out floating-point single and double loads and stores. It computes the effective address from the integer source values and the instruction fields. It checks the address and the register number before it touches memory. It then moves one or two 32-bit words between a word-wide memory port and a 32-entry floating-point register file. A double transfer is split into two word accesses in sequence: the first goes to the even register, the second to the register above it.

An operation is presented for one cycle on `issue_valid` while `busy` is low. The sequencer walks through named states:

- `ST_IDLE` waits for an operation.
- `ST_WORD0` is the first (or only) word access.
- `ST_WORD1` is the upper word of a double.
- `ST_FINISH` pulses `done` for one cycle.
- `ST_ALIGN_TRAP` and `ST_ILL_TRAP` pulse the matching trap for one cycle.

The transitions are:

- `ST_IDLE` goes to `ST_ALIGN_TRAP` on a misaligned address.
- Otherwise it goes to `ST_ILL_TRAP` on a double with an odd register.
- Otherwise it goes to `ST_WORD0`.
- `ST_WORD0` goes to `ST_WORD1` on `mem_ready` for a double, and to `ST_FINISH` on `mem_ready` for a single.
- `ST_WORD1` goes to `ST_FINISH` on `mem_ready`.
- `ST_FINISH`, `ST_ALIGN_TRAP` and `ST_ILL_TRAP` each return to `ST_IDLE` after one cycle.

Top module: `fp_ldst_seq`

## Requirements
- R1: When `imm_flag` is 1, the effective address is `rs1_val` plus `imm_field` sign-extended from 13 bits (bit 12 is the sign).
- R2: When `imm_flag` is 0, the effective address is `rs1_val + rs2_val`.
- R3: A double (`op_double`=1) whose address has any of bits 2:0 set pulses `trap_align` for exactly the one cycle after the issue edge, with no memory request and no register write. This trap takes priority over R5.
- R4: A single (`op_double`=0) whose address has any of bits 1:0 set pulses `trap_align` the same way, with no access.
- R5: An 8-byte-aligned double whose `rd_field` bit 0 is 1 pulses `trap_illegal` for exactly the one cycle after the issue edge, with no access.
- R6: A single load (`op_store`=0) makes one read at the address and writes the returned word into register `rd_field`.
- R7: A double load reads the address first into register `rd_field`, then the address plus 4 into register `rd_field`+1.
- R8: A double store (`op_store`=1) writes register `rd_field` to the address first, then register `rd_field`+1 to the address plus 4.
- R9: A single store writes register `rd_field` to the address in one write.
- R10: `mem_req` rises the cycle after the issue edge. It stays high with a stable address and direction until a cycle with `mem_ready` high. The sequencer advances only on such a cycle.
- R11: `done` is high for exactly the one cycle after the last accepted word.
- R12: `issue_valid` is ignored while `busy` is high. The access sequence and the register and memory contents are unaffected.
- R13: After reset, `busy`, `mem_req`, `rf_we`, `done`, `trap_align` and `trap_illegal` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Operation strobe, taken when `busy` is low |
| op_store | input | 1 | 1 = store, 0 = load |
| op_double | input | 1 | 1 = two-word transfer, 0 = one word |
| rd_field | input | 5 | Floating-point register number |
| imm_flag | input | 1 | Selects the immediate address form |
| imm_field | input | 13 | Signed address offset |
| rs1_val | input | 32 | First integer source value |
| rs2_val | input | 32 | Second integer source value |
| mem_req | output | 1 | Word access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted this cycle |
| rf_raddr | output | 5 | Register file read index |
| rf_rdata | input | 32 | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | Operation finished |
| trap_align | output | 1 | Address alignment trap |
| trap_illegal | output | 1 | Odd register on a double |

## Verification
Results fall due at fixed distances from the issue edge:

- A trap, or the first request, appears in the cycle after it.
- Each further word's request appears in the cycle after the previous `mem_ready` cycle.
- `done` appears in the cycle after the last `mem_ready`.
- A register file write occurs in the same cycle as the load's `mem_ready`.

The bench drives inputs and samples outputs on falling edges. A behavioural model holds a queue of expected accesses and mirror arrays of register file and memory. Every falling edge of an operation is compared with the model, including stall cycles of zero to three wait states and an issue strobe inserted mid-operation.

// File: rtl/fp_ls_pkg.sv
package fp_ls_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WORD0,
        ST_WORD1,
        ST_FINISH,
        ST_ALIGN_TRAP,
        ST_ILL_TRAP
    } seq_state_t;

    localparam int WORD_BYTES = 4;
endpackage

// File: rtl/fp_ls_agen.sv
module fp_ls_agen #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic [ADDR_W-1:0] base_val,
    input  logic [ADDR_W-1:0] index_val,
    input  logic              use_imm,
    input  logic [IMM_W-1:0]  imm_val,
    input  logic              is_double,
    input  logic              reg_lsb,
    output logic [ADDR_W-1:0] eff_addr,
    output logic              misaligned,
    output logic              odd_pair
);
    localparam int EXT_W = ADDR_W - IMM_W;

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset     = use_imm ? {{EXT_W{imm_val[IMM_W-1]}}, imm_val} : index_val;
        eff_addr   = base_val + offset;
        misaligned = is_double ? (eff_addr[2:0] != 3'b000) : (eff_addr[1:0] != 2'b00);
        odd_pair   = is_double & reg_lsb;
    end
endmodule

// File: rtl/fp_ls_ctrl.sv
module fp_ls_ctrl
    import fp_ls_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int RIDX_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              op_store,
    input  logic              op_double,
    input  logic [RIDX_W-1:0] rd_idx,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic              misaligned,
    input  logic              odd_pair,
    input  logic              mem_ready,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [RIDX_W-1:0] rf_raddr,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy,
    output logic              done,
    output logic              trap_align,
    output logic              trap_illegal
);
    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [RIDX_W-1:0] reg_q;
    logic              store_q;
    logic              double_q;
    logic [ADDR_W-1:0] cur_addr;
    logic [RIDX_W-1:0] cur_reg;

    wire accept = (state_q == ST_IDLE) && issue_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            reg_q    <= '0;
            store_q  <= 1'b0;
            double_q <= 1'b0;
        end else if (accept) begin
            addr_q   <= eff_addr;
            reg_q    <= rd_idx;
            store_q  <= op_store;
            double_q <= op_double;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (issue_valid) begin
                    if (misaligned)    state_d = ST_ALIGN_TRAP;
                    else if (odd_pair) state_d = ST_ILL_TRAP;
                    else               state_d = ST_WORD0;
                end
            end
            ST_WORD0:      if (mem_ready) state_d = double_q ? ST_WORD1 : ST_FINISH;
            ST_WORD1:      if (mem_ready) state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            ST_ALIGN_TRAP: state_d = ST_IDLE;
            ST_ILL_TRAP:   state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req      = 1'b0;
        cur_addr     = addr_q;
        cur_reg      = reg_q;
        done         = 1'b0;
        trap_align   = 1'b0;
        trap_illegal = 1'b0;
        unique case (state_q)
            ST_IDLE:       ;
            ST_WORD0:      mem_req = 1'b1;
            ST_WORD1: begin
                mem_req  = 1'b1;
                cur_addr = addr_q + ADDR_W'(WORD_BYTES);
                cur_reg  = {reg_q[RIDX_W-1:1], 1'b1};
            end
            ST_FINISH:     done = 1'b1;
            ST_ALIGN_TRAP: trap_align = 1'b1;
            ST_ILL_TRAP:   trap_illegal = 1'b1;
            default:       ;
        endcase
        busy      = (state_q != ST_IDLE);
        mem_we    = mem_req & store_q;
        mem_addr  = cur_addr;
        mem_wdata = rf_rdata;
        rf_raddr  = cur_reg;
        rf_we     = mem_req & ~store_q & mem_ready;
        rf_waddr  = cur_reg;
        rf_wdata  = mem_rdata;
    end
endmodule

// File: rtl/fp_ldst_seq.sv
module fp_ldst_seq #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int RIDX_W = 5,
    parameter int IMM_W  = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_valid,
    input  logic              op_store,
    input  logic              op_double,
    input  logic [RIDX_W-1:0] rd_field,
    input  logic              imm_flag,
    input  logic [IMM_W-1:0]  imm_field,
    input  logic [ADDR_W-1:0] rs1_val,
    input  logic [ADDR_W-1:0] rs2_val,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [RIDX_W-1:0] rf_raddr,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              busy,
    output logic              done,
    output logic              trap_align,
    output logic              trap_illegal
);
    logic [ADDR_W-1:0] eff_addr;
    logic              misaligned;
    logic              odd_pair;

    fp_ls_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_agen (
        .base_val   (rs1_val),
        .index_val  (rs2_val),
        .use_imm    (imm_flag),
        .imm_val    (imm_field),
        .is_double  (op_double),
        .reg_lsb    (rd_field[0]),
        .eff_addr   (eff_addr),
        .misaligned (misaligned),
        .odd_pair   (odd_pair)
    );

    fp_ls_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .issue_valid  (issue_valid),
        .op_store     (op_store),
        .op_double    (op_double),
        .rd_idx       (rd_field),
        .eff_addr     (eff_addr),
        .misaligned   (misaligned),
        .odd_pair     (odd_pair),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .rf_rdata     (rf_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .rf_raddr     (rf_raddr),
        .rf_we        (rf_we),
        .rf_waddr     (rf_waddr),
        .rf_wdata     (rf_wdata),
        .busy         (busy),
        .done         (done),
        .trap_align   (trap_align),
        .trap_illegal (trap_illegal)
    );
endmodule

// File: rtl/fp_ldst_seq_chk.sv
module fp_ldst_seq_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready,
    input logic              rf_we,
    input logic              done,
    input logic              trap_align,
    input logic              trap_illegal
);
    p_trap_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trap_align |-> (!mem_req && !rf_we));

    p_ill_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_illegal |-> (!mem_req && !rf_we));

    p_word_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    p_rf_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ready && !mem_we));

    p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_one_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, trap_align, trap_illegal}));
endmodule

bind fp_ldst_seq fp_ldst_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_ready    (mem_ready),
    .rf_we        (rf_we),
    .done         (done),
    .trap_align   (trap_align),
    .trap_illegal (trap_illegal)
);

// File: tb/fp_ldst_seq_bench.sv
`timescale 1ns/1ps
module fp_ldst_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_valid = 1'b0;
    logic        op_store = 1'b0;
    logic        op_double = 1'b0;
    logic [4:0]  rd_field = '0;
    logic        imm_flag = 1'b0;
    logic [12:0] imm_field = '0;
    logic [31:0] rs1_val = '0;
    logic [31:0] rs2_val = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [4:0]  rf_raddr, rf_waddr;
    logic [31:0] rf_rdata, rf_wdata;
    logic        rf_we, busy, done, trap_align, trap_illegal;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [31:0] rf_arr [32];
    logic [31:0] mem_arr [64];
    logic [31:0] exp_rf [32];
    logic [31:0] exp_mem [64];

    always #2.5 clk = ~clk;

    fp_ldst_seq u_fp_ldst_seq (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .op_store(op_store),
        .op_double(op_double), .rd_field(rd_field), .imm_flag(imm_flag),
        .imm_field(imm_field), .rs1_val(rs1_val), .rs2_val(rs2_val),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .busy(busy), .done(done), .trap_align(trap_align), .trap_illegal(trap_illegal)
    );

    assign rf_rdata  = rf_arr[rf_raddr];
    assign mem_rdata = mem_arr[mem_addr[7:2]];

    always @(posedge clk) begin
        if (rf_we) rf_arr[rf_waddr] <= rf_wdata;
        if (mem_req && mem_ready && mem_we) mem_arr[mem_addr[7:2]] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic compare_state(input string req);
        int bad = 0;
        for (int i = 0; i < 32; i++) if (rf_arr[i] !== exp_rf[i]) bad++;
        for (int i = 0; i < 64; i++) if (mem_arr[i] !== exp_mem[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    task automatic run_op(input bit st, input bit dbl, input logic [4:0] rd,
                          input logic [31:0] a, input logic [31:0] b,
                          input bit use_imm, input logic [12:0] imm,
                          input int wait_cyc, input bit poke, input string req);
        logic [31:0] ea;
        bit exp_align, exp_ill;
        int nwords;
        ea = use_imm ? a + {{19{imm[12]}}, imm} : a + b;
        exp_align = dbl ? (ea[2:0] != 0) : (ea[1:0] != 0);
        exp_ill   = !exp_align && dbl && rd[0];
        @(negedge clk);
        issue_valid = 1'b1; op_store = st; op_double = dbl; rd_field = rd;
        rs1_val = a; rs2_val = b; imm_flag = use_imm; imm_field = imm;
        @(negedge clk);
        issue_valid = 1'b0;
        if (exp_align || exp_ill) begin
            chk(trap_align == exp_align, {req, " R3/R4 trap_align"}, trap_align, exp_align);
            chk(trap_illegal == exp_ill, {req, " R5 trap_illegal"}, trap_illegal, exp_ill);
            chk(!mem_req && !rf_we, {req, " R3 no access"}, {mem_req, rf_we}, 0);
            @(negedge clk);
            chk(!trap_align && !trap_illegal && !busy && !mem_req, {req, " R3 one-cycle trap"},
                {trap_align, trap_illegal, busy, mem_req}, 0);
        end else begin
            nwords = dbl ? 2 : 1;
            for (int k = 0; k < nwords; k++) begin
                logic [31:0] waddr;
                logic [4:0] wreg;
                waddr = ea + 32'(4 * k);
                wreg  = dbl ? {rd[4:1], k[0]} : rd;
                for (int w = 0; w <= wait_cyc; w++) begin
                    chk(mem_req && mem_addr == waddr && mem_we == st,
                        {req, " R1/R2/R10 request"}, mem_addr, waddr);
                    if (poke && k == 0 && w == 0) begin
                        issue_valid = 1'b1; op_store = !st; op_double = 1'b0;
                        rd_field = 5'd1; rs1_val = 32'h4; imm_flag = 1'b0; rs2_val = 32'h0;
                    end
                    if (w == wait_cyc) begin
                        mem_ready = 1'b1;
                        if (st) chk(mem_wdata == exp_rf[wreg], {req, " R8/R9 store data"},
                                    mem_wdata, exp_rf[wreg]);
                    end
                    @(negedge clk);
                    mem_ready = 1'b0;
                    issue_valid = 1'b0;
                end
                if (st) exp_mem[waddr[7:2]] = exp_rf[wreg];
                else    exp_rf[wreg] = exp_mem[waddr[7:2]];
            end
            chk(done && !mem_req, {req, " R11 done pulse"}, {done, mem_req}, 2);
            @(negedge clk);
            chk(!done && !busy, {req, " R11 done low"}, {done, busy}, 0);
        end
        compare_state({req, " R6/R7/R8/R9/R12 contents"});
    endtask

    initial begin
        for (int i = 0; i < 32; i++) begin
            rf_arr[i] = 32'hF000_0000 | i; exp_rf[i] = 32'hF000_0000 | i;
        end
        for (int i = 0; i < 64; i++) begin
            mem_arr[i] = 32'hA500_0000 + i * 32'h101; exp_mem[i] = 32'hA500_0000 + i * 32'h101;
        end
        repeat (3) @(negedge clk);
        chk(!busy && !mem_req && !rf_we && !done && !trap_align && !trap_illegal,
            "R13 reset state", {busy, mem_req, rf_we, done, trap_align, trap_illegal}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(0, 0, 5'd3,  32'h40, 32'h0,  1, 13'h0010, 0, 0, "R1 R6 single load imm");
        run_op(0, 0, 5'd7,  32'h80, 32'h0,  1, 13'h1FF8, 2, 0, "R1 R6 negative imm");
        run_op(0, 1, 5'd10, 32'h20, 32'h18, 0, 13'h0000, 1, 0, "R2 R7 double load");
        run_op(1, 0, 5'd5,  32'h10, 32'h4,  0, 13'h0000, 3, 0, "R2 R9 single store");
        run_op(1, 1, 5'd12, 32'h50, 32'h0,  1, 13'h0010, 2, 1, "R8 R12 double store");
        run_op(0, 1, 5'd20, 32'h60, 32'h0,  1, 13'h0000, 0, 0, "R7 double readback");
        run_op(0, 1, 5'd2,  32'h64, 32'h0,  1, 13'h0000, 0, 0, "R3 double misaligned");
        run_op(1, 0, 5'd4,  32'h40, 32'h2,  0, 13'h0000, 0, 0, "R4 single misaligned");
        run_op(0, 1, 5'd9,  32'h48, 32'h0,  1, 13'h0000, 0, 0, "R5 odd register");
        run_op(1, 1, 5'd3,  32'h4C, 32'h0,  1, 13'h0000, 0, 0, "R3 R5 priority");
        run_op(0, 0, 5'd31, 32'hF8, 32'h4,  0, 13'h0000, 1, 1, "R6 R12 top register");
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule